// File: doc/BRIEF.md
# Programmable-Polynomial CRC and LFSR Engine

This block keeps a 32-bit state register and a 32-bit polynomial register. Each input byte updates the state through eight serial CRC bit-steps, and all eight steps happen in one clock cycle. The bit order is set at run time. In the default order the engine shifts right and takes the least significant data bit first. When the control bit is set, it shifts left and takes the most significant data bit first. The top term of the polynomial is never stored. The bit that leaves the register stands in for it: that bit is XORed with the data bit, and the result decides whether the polynomial is folded in. Any polynomial of 32 bits or fewer can be used. In left-shift mode, software places the polynomial and the seed in the upper bits of their registers and shifts the finished result down itself.

The same registers also work as a pseudo-random generator. A step strobe advances the state by one bit-step with a zero data bit, using the polynomial as the feedback taps. If a step would leave the state all zeros, the engine loads 1 instead, so the sequence can never lock up. A small register port reads and writes the control, polynomial and state registers. The current state is always visible on a dedicated output.

Top module: `crc_lfsr_engine`

## Requirements
- R1: After reset, the polynomial register reads 0xEDB88320, the state register reads 0xFFFFFFFF and the control register reads 0. Register addresses are: 0 = control (bit 0 is the MSB-first flag; the other bits read 0), 1 = polynomial, 2 = state, 3 = reads 0.
- R2: With the control bit at 0, an accepted byte applies eight steps, taking byte bit 0 first. Each step is fb = s[0] ^ d, then s = (s >> 1) ^ (fb ? poly : 0).
- R3: With the control bit at 1, an accepted byte applies eight steps, taking byte bit 7 first. Each step is fb = s[31] ^ d, then s = (s << 1) ^ (fb ? poly : 0).
- R4: inReady is always 1. A byte presented with inValid is absorbed in that cycle, and its result shows on stateOut one cycle later, so back-to-back bytes are taken one per cycle.
- R5: In right-shift mode, the ASCII string "123456789" gives these final states: 0x340BC6D9 with polynomial 0xEDB88320 and seed 0xFFFFFFFF; 0x00002189 with polynomial 0x00008408 and seed 0; 0x0000BB3D with polynomial 0x0000A001 and seed 0; 0x00000001 with polynomial 0x00000001 and seed 0.
- R6: In left-shift mode, with the left-justified polynomial 0x80050000 and seed 0, "123456789" gives 0xFEE80000.
- R7: lfsrStep with inValid low applies one step with data bit 0, in the direction the control bit selects. When inValid is also high, the byte is absorbed and the step strobe is ignored.
- R8: If a pseudo-random step would produce 0, the state becomes 0x00000001.
- R9: A write to the state register shows on stateOut the next cycle and overrides any byte or step in the same cycle.
- R10: Writes to the polynomial and control registers take effect from the next cycle. A byte absorbed in the same cycle uses the old values.
- R11: With no byte, no step and no state write, the state holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| inValid | input | 1 | Input byte valid |
| inReady | output | 1 | Input ready, always 1 |
| inData | input | 8 | Input byte |
| lfsrStep | input | 1 | Advance the generator by one bit-step |
| stateOut | output | 32 | Current CRC or LFSR state |

## Verification
A wrong polynomial tap, a wrong bit order or a wrong feedback bit changes stateOut in the cycle after the first byte that exercises it. The random mix compares stateOut with a bench model after every cycle, so such an error shows within a few cycles. A bad lockup substitution appears as a zero state right after the step that should have produced 1. A wrong priority between register writes, bytes and steps shows up as a one-cycle deviation in the next comparison.

// File: rtl/crcEnginePkg.sv
package crcEnginePkg;
  localparam int STATE_W = 32;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 2;
  localparam logic [STATE_W-1:0] POLY_RST  = 32'hEDB88320;
  localparam logic [STATE_W-1:0] STATE_RST = 32'hFFFFFFFF;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_POLY  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STATE = 2'd2;

  typedef struct packed {
    logic               wrPoly;
    logic               wrState;
    logic               absorb;
    logic               step;
    logic               msbFirst;
    logic [STATE_W-1:0] wrData;
  } dpCmd_t;
endpackage

// File: rtl/crcCtrl.sv
module crcCtrl
  import crcEnginePkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [STATE_W-1:0] regWrData,
  input  logic               inValid,
  input  logic               lfsrStep,
  input  logic [STATE_W-1:0] polyQ,
  input  logic [STATE_W-1:0] stateQ,
  output logic [STATE_W-1:0] regRdData,
  output dpCmd_t             cmd
);
  logic msbFirstQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) msbFirstQ <= 1'b0;
    else if (regWrEn && regAddr == ADDR_CTRL) msbFirstQ <= regWrData[0];
  end

  always_comb begin
    cmd.wrPoly   = regWrEn && (regAddr == ADDR_POLY);
    cmd.wrState  = regWrEn && (regAddr == ADDR_STATE);
    cmd.absorb   = inValid;
    cmd.step     = lfsrStep && !inValid;
    cmd.msbFirst = msbFirstQ;
    cmd.wrData   = regWrData;
  end

  always_comb begin
    case (regAddr)
      ADDR_CTRL:  regRdData = {{(STATE_W-1){1'b0}}, msbFirstQ};
      ADDR_POLY:  regRdData = polyQ;
      ADDR_STATE: regRdData = stateQ;
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/crcDatapath.sv
module crcDatapath
  import crcEnginePkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  dpCmd_t             cmd,
  input  logic [BYTE_W-1:0]  inData,
  output logic [STATE_W-1:0] polyQ,
  output logic [STATE_W-1:0] stateQ
);
  function automatic logic [STATE_W-1:0] bitStep(
    input logic [STATE_W-1:0] s, input logic [STATE_W-1:0] p,
    input logic d, input logic msb);
    logic fb;
    if (msb) begin
      fb = s[STATE_W-1] ^ d;
      return (s << 1) ^ (fb ? p : '0);
    end
    fb = s[0] ^ d;
    return (s >> 1) ^ (fb ? p : '0);
  endfunction

  logic [STATE_W-1:0] byteNext;
  logic [STATE_W-1:0] stepNext;

  always_comb begin
    byteNext = stateQ;
    for (int i = 0; i < BYTE_W; i++) begin
      byteNext = bitStep(byteNext, polyQ,
                         cmd.msbFirst ? inData[BYTE_W-1-i] : inData[i],
                         cmd.msbFirst);
    end
  end

  always_comb begin
    stepNext = bitStep(stateQ, polyQ, 1'b0, cmd.msbFirst);
    if (stepNext == '0) stepNext = {{(STATE_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polyQ  <= POLY_RST;
      stateQ <= STATE_RST;
    end else begin
      if (cmd.wrPoly) polyQ <= cmd.wrData;
      if (cmd.wrState)     stateQ <= cmd.wrData;
      else if (cmd.absorb) stateQ <= byteNext;
      else if (cmd.step)   stateQ <= stepNext;
    end
  end
endmodule

// File: rtl/crc_lfsr_engine.sv
module crc_lfsr_engine
  import crcEnginePkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [STATE_W-1:0] regWrData,
  output logic [STATE_W-1:0] regRdData,
  input  logic               inValid,
  output logic               inReady,
  input  logic [BYTE_W-1:0]  inData,
  input  logic               lfsrStep,
  output logic [STATE_W-1:0] stateOut
);
  dpCmd_t             cmd;
  logic [STATE_W-1:0] polyQ;
  logic [STATE_W-1:0] stateQ;

  crcCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .inValid(inValid), .lfsrStep(lfsrStep),
    .polyQ(polyQ), .stateQ(stateQ), .regRdData(regRdData), .cmd(cmd)
  );

  crcDatapath u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .inData(inData),
    .polyQ(polyQ), .stateQ(stateQ)
  );

  assign inReady  = 1'b1;
  assign stateOut = stateQ;
endmodule

// File: rtl/crcEngineChecker.sv
module crcEngineChecker
  import crcEnginePkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [STATE_W-1:0] regWrData,
  input logic               inValid,
  input logic               inReady,
  input logic               lfsrStep,
  input logic [STATE_W-1:0] stateOut
);
  logic stateWr;
  assign stateWr = regWrEn && (regAddr == ADDR_STATE);

  p_ready_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    inReady);

  p_state_write_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    stateWr |=> stateOut == $past(regWrData));

  p_no_lockup_r8: assert property (@(posedge clk) disable iff (!rstN)
    (lfsrStep && !inValid && !stateWr) |=> stateOut != '0);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && !lfsrStep && !stateWr) |=> $stable(stateOut));
endmodule

bind crc_lfsr_engine crcEngineChecker u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .inValid(inValid), .inReady(inReady),
  .lfsrStep(lfsrStep), .stateOut(stateOut)
);

// File: tb/crc_lfsr_engine_tb.sv
module crc_lfsr_engine_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [7:0]  inData = '0;
  logic        lfsrStep = 1'b0;
  logic [31:0] stateOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] mPoly, mState;
  logic        mMsb;

  always #2.5 clk = ~clk;

  crc_lfsr_engine u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .inValid(inValid),
    .inReady(inReady), .inData(inData), .lfsrStep(lfsrStep),
    .stateOut(stateOut)
  );

  function automatic logic [31:0] mStep(logic [31:0] s, logic [31:0] p,
                                        logic d, logic msb);
    logic fb;
    if (msb) begin
      fb = s[31] ^ d;
      s = {s[30:0], 1'b0};
    end else begin
      fb = s[0] ^ d;
      s = {1'b0, s[31:1]};
    end
    return fb ? (s ^ p) : s;
  endfunction

  function automatic logic [31:0] mByte(logic [31:0] s, logic [31:0] p,
                                        logic [7:0] b, logic msb);
    for (int k = 0; k < 8; k++)
      s = mStep(s, p, msb ? b[7-k] : b[k], msb);
    return s;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic [1:0] a, logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a == 2'd0) mMsb = d[0];
    if (a == 2'd1) mPoly = d;
    if (a == 2'd2) mState = d;
  endtask

  task automatic rdCheck(string req, logic [1:0] a, logic [31:0] exp);
    regAddr = a;
    #0.5;
    check(req, regRdData, exp);
  endtask

  task automatic sendStr(string str);
    for (int k = 0; k < str.len(); k++) begin
      inValid = 1'b1; inData = str[k];
      mState = mByte(mState, mPoly, str[k], mMsb);
      @(negedge clk);
    end
    inValid = 1'b0;
  endtask

  task automatic runString(string req, logic msb, logic [31:0] p,
                           logic [31:0] seed, logic [31:0] exp);
    wrReg(2'd0, {31'd0, msb});
    wrReg(2'd1, p);
    wrReg(2'd2, seed);
    sendStr("123456789");
    check(req, stateOut, exp);
    check({req, " model"}, stateOut, mState);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    mPoly = 32'hEDB88320; mState = 32'hFFFFFFFF; mMsb = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset values and address map
    rdCheck("R1 ctrl", 2'd0, 32'd0);
    rdCheck("R1 poly", 2'd1, 32'hEDB88320);
    rdCheck("R1 state", 2'd2, 32'hFFFFFFFF);
    rdCheck("R1 addr3", 2'd3, 32'd0);
    check("R4 ready", {31'd0, inReady}, 32'd1);

    // R5 right-shift standard results
    runString("R5 crc32", 1'b0, 32'hEDB88320, 32'hFFFFFFFF, 32'h340BC6D9);
    runString("R5 ccitt", 1'b0, 32'h00008408, 32'h0, 32'h00002189);
    runString("R5 crc16", 1'b0, 32'h0000A001, 32'h0, 32'h0000BB3D);
    runString("R5 parity", 1'b0, 32'h00000001, 32'h0, 32'h00000001);
    // R6 left-shift, left-justified
    runString("R6 msb16", 1'b1, 32'h80050000, 32'h0, 32'hFEE80000);
    rdCheck("R3 ctrl readback", 2'd0, 32'd1);

    // R8 lockup: poly 0, state 1 would step to 0
    wrReg(2'd0, 32'd0);
    wrReg(2'd1, 32'd0);
    wrReg(2'd2, 32'd1);
    lfsrStep = 1'b1; @(negedge clk); lfsrStep = 1'b0;
    check("R8 lockup", stateOut, 32'd1);
    wrReg(2'd2, 32'd0);
    lfsrStep = 1'b1; @(negedge clk); lfsrStep = 1'b0;
    check("R8 zero seed", stateOut, 32'd1);

    // R7 step in both directions, and byte priority
    wrReg(2'd1, 32'hB4BCD35C);
    wrReg(2'd2, 32'h12345679);
    lfsrStep = 1'b1; @(negedge clk); lfsrStep = 1'b0;
    mState = mStep(32'h12345679, 32'hB4BCD35C, 1'b0, 1'b0);
    check("R7 step lsb", stateOut, mState);
    wrReg(2'd0, 32'd1);
    lfsrStep = 1'b1; @(negedge clk); lfsrStep = 1'b0;
    mState = mStep(mState, mPoly, 1'b0, 1'b1);
    check("R7 step msb", stateOut, mState);
    lfsrStep = 1'b1; inValid = 1'b1; inData = 8'hA5;
    mState = mByte(mState, mPoly, 8'hA5, 1'b1);
    @(negedge clk); lfsrStep = 1'b0; inValid = 1'b0;
    check("R7 byte over step", stateOut, mState);

    // R9 state write overrides byte
    inValid = 1'b1; inData = 8'h3C;
    wrReg(2'd2, 32'hCAFEF00D);
    inValid = 1'b0;
    check("R9 write wins", stateOut, 32'hCAFEF00D);

    // R10 poly and control writes use old values in same cycle
    inValid = 1'b1; inData = 8'h5A;
    mState = mByte(mState, mPoly, 8'h5A, mMsb);
    wrReg(2'd1, 32'h04C11DB7);
    mState = mByte(mState, mPoly, 8'h5A, mMsb);
    wrReg(2'd0, 32'd0);
    inValid = 1'b0;
    check("R10 old poly/ctrl", stateOut, mState);

    // R11 idle hold
    repeat (3) @(negedge clk);
    check("R11 hold", stateOut, mState);

    // R2 R3 R4 random mix
    void'($urandom(32'h1357));
    for (int n = 0; n < 400; n++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel == 0) begin
        wrReg(2'd0, {31'd0, 1'($urandom_range(0, 1))});
      end else if (sel == 1) begin
        wrReg(2'd1, $urandom());
      end else if (sel == 2) begin
        lfsrStep = 1'b1;
        mState = mStep(mState, mPoly, 1'b0, mMsb);
        if (mState == 32'd0) mState = 32'd1;
        @(negedge clk); lfsrStep = 1'b0;
        check("R7 random step", stateOut, mState);
      end else begin
        inValid = 1'b1; inData = 8'($urandom());
        lfsrStep = 1'($urandom_range(0, 1));
        mState = mByte(mState, mPoly, inData, mMsb);
        @(negedge clk); inValid = 1'b0; lfsrStep = 1'b0;
        check(mMsb ? "R3 random byte" : "R2 random byte", stateOut, mState);
      end
    end
    rdCheck("R1 final state readback", 2'd2, mState);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule